// File: doc/BRIEF.md
# Flash Buffered Program Command Sequencer

This block is the command front end of a parallel NOR flash model. It watches single-cycle bus writes for a multi-step buffered-program sequence. Two fixed unlock writes come first, then a setup write that names the target block, then a count write that gives how many words follow. Those words are address/data pairs collected in a small write buffer. A confirm write then starts programming, and the buffered words are merged into a synchronous cell array.

While programming runs, and after any error, bus reads return a status word instead of array contents. The sequencer rejects any bad sequence by entering a sticky error state:
- a count too large for the buffer;
- a load outside the page of the first load;
- a count or confirm write aimed at another block;
- a wrong confirm code.

Programming can only clear bits. An attempted 0-to-1 change is reported as a program failure. A buffer whose first load is not at the start of its page takes twice the base programming time.

Top module: `flash_bufprog_seq`

## Requirements
- R1: After reset `busy` is 0 and every array word reads as FFh (erased).
- R2: The words are programmed by this write sequence: AAh at address 555h, then 55h at 2AAh, then setup code 25h at any address of the target block, then count N at an address in that block, then N+1 loads, then confirm code 29h at an address in that block. A read issued on one cycle returns its data on the next cycle. Words of the page that were not loaded keep their value. If an unlock write has the wrong address or data, the sequencer returns to read mode without effect.
- R3: A count value N of BUF_WORDS or more aborts the sequence. N = BUF_WORDS-1 is accepted.
- R4: Several writes abort the sequence: a load whose page (address divided by BUF_WORDS) differs from the first load's page, a first load outside the block, and a count or confirm write outside the block named at setup. A block is BLK_WORDS words.
- R5: Every load uses up one count, even if it repeats an earlier address. For a repeated address the last data loaded is what gets programmed.
- R6: After the last load, any write other than 29h to the block aborts the sequence.
- R7: The stored word becomes old AND new. Any bit that is 0 in the old word and 1 in the new data sets the fail flag, and the sequencer ends in the error state.
- R8: `busy` is high for exactly BASE_CYC cycles after the confirm write if the first load sat at page offset 0. It is high for 2*BASE_CYC cycles otherwise.
- R9: A read during programming or in the error state returns the status word. Bit 7 is the inverse of bit 7 of the last loaded data. Bit 6 flips on every such read. Bit 5 is the fail flag. Bit 1 is the abort flag. All other bits are 0.
- R10: The error state is sticky: writes other than F0h are ignored there. A write of F0h clears both flags and returns to read mode. A successful program returns to read mode directly.
- R11: Bus writes while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Bus write strobe, one write per cycle |
| bus_re | input | 1 | Bus read strobe |
| bus_addr | input | AW | Word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, registered one cycle after `bus_re` |
| busy | output | 1 | High while programming runs |

## Verification
A sweep programs fresh pages for every start offset and every word count that fits the page. Loads go in ascending order for some runs and descending order for others. This separates alignment, which follows the first load's offset, from which words were loaded, and it checks that the untouched words of each page survive. Separate patterns are used for the remaining cases:
- Each abort cause, with its sticky status, the F0h release and an unchanged array afterwards.
- A triple write to one address, which only completes if every load uses up a count.
- A 0-to-1 reprogram next to a legal bit-clearing one.
- Back-to-back status reads while busy.
- Junk writes during programming and a broken unlock, each followed by a write sequence that would change the array if the junk had been taken.

// File: rtl/fbp_pkg.sv
package fbp_pkg;
  typedef enum logic [2:0] {
    ST_READ, ST_UNL1, ST_UNL2, ST_CNT, ST_LOAD, ST_CONF, ST_PROG, ST_ERR
  } fbp_state_e;

  localparam logic [7:0] CODE_KEY1  = 8'hAA;
  localparam logic [7:0] CODE_KEY2  = 8'h55;
  localparam logic [7:0] CODE_SETUP = 8'h25;
  localparam logic [7:0] CODE_CONF  = 8'h29;
  localparam logic [7:0] CODE_CLEAR = 8'hF0;
  localparam int KEY1_ADDR = 'h555;
  localparam int KEY2_ADDR = 'h2AA;
endpackage

// File: rtl/flash_wbuf.sv
module flash_wbuf #(
  parameter int DW        = 8,
  parameter int BUF_WORDS = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         we,
  input  logic [$clog2(BUF_WORDS)-1:0] woff,
  input  logic [DW-1:0]                wdata,
  input  logic [$clog2(BUF_WORDS)-1:0] roff,
  output logic [DW-1:0]                rdata,
  output logic                         rvalid
);
  localparam int OFW = $clog2(BUF_WORDS);

  logic [BUF_WORDS-1:0][DW-1:0] ent_flat;
  logic [BUF_WORDS-1:0]         vld_flat;

  for (genvar e = 0; e < BUF_WORDS; e++) begin : g_ent
    logic [DW-1:0] dat_q;
    logic          vld_q;
    logic          hit;
    assign hit = we && (woff == OFW'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dat_q <= '0;
        vld_q <= 1'b0;
      end else begin
        if (hit) dat_q <= wdata;
        if (clr) vld_q <= 1'b0;
        else if (hit) vld_q <= 1'b1;
      end
    end

    assign ent_flat[e] = dat_q;
    assign vld_flat[e] = vld_q;
  end

  assign rdata  = ent_flat[roff];
  assign rvalid = vld_flat[roff];
endmodule

// File: rtl/flash_cell_array.sv
module flash_cell_array #(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          pg_we,
  input  logic          pg_valid,
  input  logic [AW-1:0] pg_addr,
  input  logic [DW-1:0] pg_data,
  output logic          pg_bad
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] old_w;
  logic          do_wr;

  assign old_w   = mem_q[pg_addr];
  assign do_wr   = pg_we && pg_valid;
  assign pg_bad  = do_wr && (|(pg_data & ~old_w));
  assign rd_data = mem_q[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (do_wr) begin
      mem_q[pg_addr] <= old_w & pg_data;
    end
  end
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import fbp_pkg::*;
#(
  parameter int AW        = 12,
  parameter int DW        = 8,
  parameter int BUF_WORDS = 8,
  parameter int BLK_WORDS = 1024,
  parameter int BASE_CYC  = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [AW-1:0]                  addr,
  input  logic [DW-1:0]                  wdata,
  input  logic                           mem_bad,
  output fbp_state_e                     state_o,
  output logic                           buf_clr,
  output logic                           buf_we,
  output logic [$clog2(BUF_WORDS)-1:0]   buf_off,
  output logic                           prog_we,
  output logic [AW-1:0]                  prog_addr,
  output logic [$clog2(BUF_WORDS+1)-1:0] rem_o,
  output logic                           abort_o,
  output logic                           fail_o,
  output logic                           last_d7_o
);
  localparam int OFW = $clog2(BUF_WORDS);
  localparam int BLW = $clog2(BLK_WORDS);
  localparam int CW  = $clog2(BUF_WORDS + 1);
  localparam int IW  = $clog2(BUF_WORDS + 1);
  localparam int TW  = $clog2(2 * BASE_CYC + 1);
  localparam int PW  = AW - OFW;
  localparam int BW  = AW - BLW;
  localparam logic [IW-1:0] IDX_END = IW'(BUF_WORDS);
  localparam logic [TW-1:0] T_ALN   = TW'(BASE_CYC);
  localparam logic [TW-1:0] T_UNA   = TW'(2 * BASE_CYC);
  localparam logic [AW-1:0] A_KEY1  = AW'(KEY1_ADDR);
  localparam logic [AW-1:0] A_KEY2  = AW'(KEY2_ADDR);

  fbp_state_e    state_q, state_d;
  logic [BW-1:0] blk_q, blk_d;
  logic [PW-1:0] page_q, page_d;
  logic [CW-1:0] rem_q, rem_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          first_q, first_d;
  logic          aln_q, aln_d;
  logic          abort_q, abort_d;
  logic          fail_q, fail_d;
  logic          d7_q, d7_d;

  logic [BW-1:0]  a_blk;
  logic [PW-1:0]  a_page;
  logic [OFW-1:0] a_off;
  logic [7:0]     code;
  logic           load_ok;

  assign a_blk  = addr[AW-1:BLW];
  assign a_page = addr[AW-1:OFW];
  assign a_off  = addr[OFW-1:0];
  assign code   = wdata[7:0];

  assign load_ok   = first_q ? (a_blk == blk_q) : (a_page == page_q);
  assign prog_we   = (state_q == ST_PROG) && (idx_q < IDX_END);
  assign prog_addr = {page_q, idx_q[OFW-1:0]};
  assign buf_off   = a_off;

  always_comb begin
    state_d = state_q;
    blk_d   = blk_q;
    page_d  = page_q;
    rem_d   = rem_q;
    idx_d   = idx_q;
    tmr_d   = tmr_q;
    first_d = first_q;
    aln_d   = aln_q;
    abort_d = abort_q;
    fail_d  = fail_q;
    d7_d    = d7_q;
    buf_clr = 1'b0;
    buf_we  = 1'b0;
    unique case (state_q)
      ST_READ: begin
        if (we && addr == A_KEY1 && code == CODE_KEY1) state_d = ST_UNL1;
      end
      ST_UNL1: begin
        if (we) state_d = (addr == A_KEY2 && code == CODE_KEY2) ? ST_UNL2 : ST_READ;
      end
      ST_UNL2: begin
        if (we) begin
          if (code == CODE_SETUP) begin
            blk_d   = a_blk;
            state_d = ST_CNT;
          end else begin
            state_d = ST_READ;
          end
        end
      end
      ST_CNT: begin
        if (we) begin
          if (a_blk != blk_q || wdata >= DW'(BUF_WORDS)) begin
            abort_d = 1'b1;
            state_d = ST_ERR;
          end else begin
            rem_d   = CW'(wdata) + CW'(1);
            first_d = 1'b1;
            buf_clr = 1'b1;
            state_d = ST_LOAD;
          end
        end
      end
      ST_LOAD: begin
        if (we) begin
          if (!load_ok) begin
            abort_d = 1'b1;
            state_d = ST_ERR;
          end else begin
            if (first_q) begin
              page_d  = a_page;
              aln_d   = (a_off == '0);
              first_d = 1'b0;
            end
            buf_we = 1'b1;
            d7_d   = wdata[7];
            rem_d  = rem_q - CW'(1);
            if (rem_q == CW'(1)) state_d = ST_CONF;
          end
        end
      end
      ST_CONF: begin
        if (we) begin
          if (a_blk == blk_q && code == CODE_CONF) begin
            tmr_d   = aln_q ? T_ALN : T_UNA;
            idx_d   = '0;
            fail_d  = 1'b0;
            state_d = ST_PROG;
          end else begin
            abort_d = 1'b1;
            state_d = ST_ERR;
          end
        end
      end
      ST_PROG: begin
        if (prog_we) idx_d = idx_q + IW'(1);
        if (mem_bad) fail_d = 1'b1;
        tmr_d = tmr_q - TW'(1);
        if (tmr_q == TW'(1)) state_d = (fail_q || mem_bad) ? ST_ERR : ST_READ;
      end
      ST_ERR: begin
        if (we && code == CODE_CLEAR) begin
          abort_d = 1'b0;
          fail_d  = 1'b0;
          state_d = ST_READ;
        end
      end
      default: state_d = ST_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_READ;
      blk_q   <= '0;
      page_q  <= '0;
      rem_q   <= '0;
      idx_q   <= '0;
      tmr_q   <= '0;
      first_q <= 1'b0;
      aln_q   <= 1'b0;
      abort_q <= 1'b0;
      fail_q  <= 1'b0;
      d7_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      blk_q   <= blk_d;
      page_q  <= page_d;
      rem_q   <= rem_d;
      idx_q   <= idx_d;
      tmr_q   <= tmr_d;
      first_q <= first_d;
      aln_q   <= aln_d;
      abort_q <= abort_d;
      fail_q  <= fail_d;
      d7_q    <= d7_d;
    end
  end

  assign state_o   = state_q;
  assign rem_o     = rem_q;
  assign abort_o   = abort_q;
  assign fail_o    = fail_q;
  assign last_d7_o = d7_q;
endmodule

// File: rtl/flash_bufprog_seq.sv
module flash_bufprog_seq
  import fbp_pkg::*;
#(
  parameter int AW        = 12,
  parameter int DW        = 8,
  parameter int BUF_WORDS = 8,
  parameter int BLK_WORDS = 1024,
  parameter int BASE_CYC  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic          bus_re,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          busy
);
  localparam int OFW = $clog2(BUF_WORDS);
  localparam int CW  = $clog2(BUF_WORDS + 1);

  fbp_state_e     st;
  logic           b_clr, b_we, b_vld;
  logic [OFW-1:0] b_off;
  logic [DW-1:0]  b_data;
  logic           p_we, p_bad;
  logic [AW-1:0]  p_addr;
  logic [CW-1:0]  rem;
  logic           abort_f, fail_f, d7;
  logic [DW-1:0]  cell_rd;
  logic [DW-1:0]  stat_w;
  logic [DW-1:0]  rdata_q;
  logic           tog_q;
  logic           show_stat;

  flash_cmd_fsm #(
    .AW(AW), .DW(DW), .BUF_WORDS(BUF_WORDS), .BLK_WORDS(BLK_WORDS), .BASE_CYC(BASE_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .mem_bad(p_bad), .state_o(st), .buf_clr(b_clr), .buf_we(b_we), .buf_off(b_off),
    .prog_we(p_we), .prog_addr(p_addr), .rem_o(rem), .abort_o(abort_f),
    .fail_o(fail_f), .last_d7_o(d7)
  );

  flash_wbuf #(.DW(DW), .BUF_WORDS(BUF_WORDS)) u_wbuf (
    .clk(clk), .rst_n(rst_n), .clr(b_clr), .we(b_we), .woff(b_off), .wdata(bus_wdata),
    .roff(p_addr[OFW-1:0]), .rdata(b_data), .rvalid(b_vld)
  );

  flash_cell_array #(.AW(AW), .DW(DW)) u_cells (
    .clk(clk), .rst_n(rst_n), .rd_addr(bus_addr), .rd_data(cell_rd),
    .pg_we(p_we), .pg_valid(b_vld), .pg_addr(p_addr), .pg_data(b_data), .pg_bad(p_bad)
  );

  assign show_stat = (st == ST_PROG) || (st == ST_ERR);

  always_comb begin
    stat_w    = '0;
    stat_w[7] = ~d7;
    stat_w[6] = tog_q;
    stat_w[5] = fail_f;
    stat_w[1] = abort_f;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      tog_q   <= 1'b0;
    end else if (bus_re) begin
      rdata_q <= show_stat ? stat_w : cell_rd;
      if (show_stat) tog_q <= ~tog_q;
    end
  end

  assign bus_rdata = rdata_q;
  assign busy      = (st == ST_PROG);
endmodule

// File: rtl/flash_bufprog_chk.sv
module flash_bufprog_chk
  import fbp_pkg::*;
#(
  parameter int DW        = 8,
  parameter int CW        = 4,
  parameter int BUF_WORDS = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_we,
  input logic          bus_re,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input logic          busy,
  input fbp_state_e    st,
  input logic [CW-1:0] rem,
  input logic          abort_f,
  input logic          fail_f
);
  assert_confirm_before_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(bus_we) && $past(bus_wdata[7:0]) == CODE_CONF));

  assert_count_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rem <= CW'(BUF_WORDS));

  assert_abort_lands_in_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abort_f) |-> (st == ST_ERR));

  assert_fail_ends_in_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && fail_f) |-> (st == ST_ERR));

  assert_busy_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (st == ST_READ || st == ST_ERR));

  assert_toggle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_re) ##1 (busy && bus_re) |=> (bus_rdata[6] != $past(bus_rdata[6])));

  assert_err_reads_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ERR && bus_re) |=> (bus_rdata[5] || bus_rdata[1]));

  assert_fail_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_f && !busy && !(bus_we && bus_wdata[7:0] == CODE_CLEAR)) |=> fail_f);
endmodule

bind flash_bufprog_seq flash_bufprog_chk #(.DW(DW), .CW(CW), .BUF_WORDS(BUF_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .busy(busy), .st(st), .rem(rem), .abort_f(abort_f), .fail_f(fail_f)
);

// File: tb/tb_flash_bufprog_seq.sv
`timescale 1ns/1ps
module tb_flash_bufprog_seq;
  localparam int AW = 12, DW = 8, BUFW = 8, BLKW = 1024, BASE = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, bus_we, bus_re, busy;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;

  flash_bufprog_seq #(.AW(AW), .DW(DW), .BUF_WORDS(BUFW), .BLK_WORDS(BLKW), .BASE_CYC(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy)
  );

  int errs = 0, checks = 0;
  bit finished = 0;
  logic [7:0] mdl [1 << AW];
  logic [7:0] rd, rd2, v;
  logic [11:0] base;
  int cyc, p, fo;
  bit rev;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic brd(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic start_seq(input logic [11:0] blk_a, input logic [11:0] cnt_a, input logic [7:0] n);
    bwr(12'h555, 8'hAA);
    bwr(12'h2AA, 8'h55);
    bwr(blk_a, 8'h25);
    bwr(cnt_a, n);
  endtask

  task automatic wait_idle(output int c);
    c = 0;
    while (busy && c < 1000) begin
      c++;
      @(negedge clk);
    end
  endtask

  function automatic logic [7:0] pat(input int pg, input int off);
    return 8'(pg * 37 + off * 11 + 5);
  endfunction

  task automatic abort_expect(input string req, input logic [11:0] probe);
    logic [7:0] r;
    brd(probe, r);
    chk({req, " abort status"}, int'(r & 8'h3F), 'h02);
    chk({req, " not busy"}, int'(busy), 0);
    bwr(12'h555, 8'hAA);
    brd(probe, r);
    chk("R10 sticky after write", int'(r & 8'h3F), 'h02);
    bwr(12'h000, 8'hF0);
    brd(probe, r);
    chk({req, " array intact after clear"}, int'(r), int'(mdl[probe]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) mdl[i] = 8'hFF;
    rst_n = 1'b0; bus_we = 1'b0; bus_re = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 busy after reset", int'(busy), 0);
    brd(12'h000, rd); chk("R1 erased 000", int'(rd), 'hFF);
    brd(12'h555, rd); chk("R1 erased 555", int'(rd), 'hFF);
    brd(12'hFFF, rd); chk("R1 erased FFF", int'(rd), 'hFF);

    // R2/R8 sweep over start offset, count and load order
    p = 1;
    for (int off = 0; off < BUFW; off++) begin
      for (int cnt = 1; off + cnt <= BUFW; cnt++) begin
        base = 12'(p * BUFW);
        rev  = ((off + cnt) % 2) == 1;
        start_seq(base, base + 12'(BUFW - 1), 8'(cnt - 1));
        for (int k = 0; k < cnt; k++) begin
          int o;
          o = rev ? off + cnt - 1 - k : off + k;
          bwr(base + 12'(o), pat(p, o));
          mdl[base + 12'(o)] = mdl[base + 12'(o)] & pat(p, o);
        end
        fo = rev ? off + cnt - 1 : off;
        bwr(base, 8'h29);
        wait_idle(cyc);
        chk("R8 program duration", cyc, (fo == 0) ? BASE : 2 * BASE);
        for (int o = 0; o < BUFW; o++) begin
          brd(base + 12'(o), rd);
          chk("R2 page readback", int'(rd), int'(mdl[base + 12'(o)]));
        end
        p++;
      end
    end

    // R3 count limit
    start_seq(12'(40 * BUFW), 12'(40 * BUFW), 8'(BUFW));
    abort_expect("R3", 12'(40 * BUFW));

    // R4 load outside first page
    start_seq(12'(41 * BUFW), 12'(41 * BUFW), 8'd1);
    bwr(12'(41 * BUFW), 8'h00);
    bwr(12'(42 * BUFW), 8'h00);
    abort_expect("R4 page", 12'(41 * BUFW));

    // R4 count write to another block
    start_seq(12'h005, 12'h405, 8'd0);
    abort_expect("R4 count block", 12'h005);

    // R4 confirm to another block
    start_seq(12'(44 * BUFW), 12'(44 * BUFW), 8'd0);
    bwr(12'(44 * BUFW), 8'h00);
    bwr(12'h800, 8'h29);
    abort_expect("R4 confirm block", 12'(44 * BUFW));

    // R6 wrong confirm code
    start_seq(12'(45 * BUFW), 12'(45 * BUFW), 8'd0);
    bwr(12'(45 * BUFW), 8'h00);
    bwr(12'(45 * BUFW), 8'h30);
    abort_expect("R6", 12'(45 * BUFW));

    // R5 repeated address consumes counts, last data wins
    base = 12'(43 * BUFW);
    start_seq(base, base, 8'd2);
    bwr(base + 12'd2, 8'h11);
    bwr(base + 12'd2, 8'h22);
    bwr(base + 12'd2, 8'h3C);
    bwr(base, 8'h29);
    wait_idle(cyc);
    chk("R5 unaligned repeat duration", cyc, 2 * BASE);
    brd(base + 12'd2, rd); chk("R5 last data wins", int'(rd), 'h3C);
    brd(base + 12'd1, rd); chk("R5 neighbour untouched", int'(rd), 'hFF);

    // R7 0-to-1 attempt fails, array keeps old AND new
    v = mdl[BUFW];
    start_seq(12'(BUFW), 12'(BUFW), 8'd0);
    bwr(12'(BUFW), 8'hFF);
    bwr(12'(BUFW), 8'h29);
    wait_idle(cyc);
    brd(12'(BUFW), rd); chk("R7 fail status", int'(rd & 8'h3F), 'h20);
    bwr(12'h000, 8'hF0);
    brd(12'(BUFW), rd); chk("R7 old value kept", int'(rd), int'(v));
    start_seq(12'(BUFW), 12'(BUFW), 8'd0);
    bwr(12'(BUFW), v & 8'h0F);
    bwr(12'(BUFW), 8'h29);
    wait_idle(cyc);
    brd(12'(BUFW), rd); chk("R7 legal bit clear", int'(rd), int'(v & 8'h0F));
    mdl[BUFW] = v & 8'h0F;

    // R9 status while busy
    base = 12'(50 * BUFW);
    start_seq(base, base, 8'd0);
    bwr(base, 8'h80);
    bwr(base, 8'h29);
    brd(base, rd);
    brd(base, rd2);
    chk("R9 dq7 inverse of last bit7", int'(rd[7]), 0);
    chk("R9 flags clear while busy", int'(rd & 8'h3F), 0);
    chk("R9 dq6 toggles", int'(rd[6] ^ rd2[6]), 1);
    wait_idle(cyc);
    brd(base, rd); chk("R10 read mode after success", int'(rd), 'h80);

    // R11 writes during busy are ignored
    base = 12'(51 * BUFW);
    start_seq(base, base, 8'd0);
    bwr(base, 8'hA5);
    bwr(base, 8'h29);
    bwr(12'h555, 8'hAA);
    bwr(12'h2AA, 8'h55);
    bwr(base, 8'h25);
    wait_idle(cyc);
    bwr(base + 12'd1, 8'h00);
    bwr(base + 12'd1, 8'h00);
    bwr(base, 8'h29);
    chk("R11 no program started", int'(busy), 0);
    brd(base, rd); chk("R11 data programmed", int'(rd), 'hA5);
    brd(base + 12'd1, rd); chk("R11 junk not taken", int'(rd), 'hFF);

    // R2 broken unlock has no effect
    base = 12'(52 * BUFW);
    bwr(12'h555, 8'hAA);
    bwr(12'h2AA, 8'h56);
    bwr(base, 8'h25);
    bwr(base, 8'h00);
    bwr(base, 8'h00);
    bwr(base, 8'h29);
    chk("R2 broken unlock not busy", int'(busy), 0);
    brd(base, rd); chk("R2 broken unlock no write", int'(rd), 'hFF);

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule